// File: doc/BRIEF.md
# Key-Guarded Pin Mapping Crossbar

This block routes internal peripheral output signals onto a set of physical pin outputs. Every pin owns one byte-wide selector register. A selector code picks which peripheral output drives that pin, forces the pin low, or parks the pin in an analog mode. In analog mode the pin's digital output logic is turned off.

Software changes the selectors through a small register bus. A 16-bit key must be written to the key register first, and this opens a timed write window. The window closes when a wrong key is written, or when its cycle counter reaches 32. A reconfiguration-enable bit in the control register sets the policy. When it is clear, the mapping can be changed in only one window after each reset. When it is set, windows can be reopened at any time.

Register addresses are 0 for the key, 1 for control, and 2 + n for the selector of pin n. Reads are registered and appear one cycle after the address is presented.

Top module: `pinmux_xbar`

## Requirements
- R1: After reset the bus is locked. Reading address 0 returns 0x96A5. Selector n holds n+1, so pin n follows peripheral output n. The control register reads 0.
- R2: Writing 0x2D52 to address 0 opens the write window. While the window is open, address 0 reads 0xA596 and control bit 2 reads 1.
- R3: While the window is open, a write to address 2+n stores the low byte as selector n. Code c in 1..NUM_SRC makes pin n follow peripheral output c-1, with pin outputs registered.
- R4: While locked, writes to selectors and to control are ignored, and they set a sticky violation flag in control bit 1.
- R5: While the window is open, writing any value other than 0x2D52 to address 0 closes the window at once. While locked, such a write has no effect.
- R6: The window counter advances every cycle while the window is open. The window closes when the counter reaches 32.
- R7: If a window closes while control bit 0 (reconfiguration enable) is 0, the block is marked as configured and control bit 3 reads 1. Once configured, further correct keys are refused until the next reset, and reset clears the marker.
- R8: While control bit 0 is 1, a correct key reopens the window after a previous window has closed.
- R9: Code 0 drives the pin low. Codes above NUM_SRC, other than 0xFF, also drive the pin low.
- R10: Code 0xFF drives the pin low and sets that pin's analog-disable output.
- R11: A control write made while the window is open stores bit 0 as reconfiguration enable. If bit 1 of the written value is 1, the violation flag is cleared.
- R12: Writing the correct key while the window is open restarts the window counter from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| periph_in | input | NUM_SRC | Internal peripheral output signals |
| pin_out | output | NUM_PINS | Registered pin drive values |
| pin_analog_dis | output | NUM_PINS | Per-pin digital-logic disable for analog mode |

## Verification
The bench builds the block with 8 pins, 12 peripheral sources and the 32-cycle window. Because there are fewer pins than sources, every pin has a real identity source after reset. Codes 13 to 254 remain available as out-of-range selectors. With a 32-cycle window, the bench can wait well past expiry and can also restart a window midway and still write after the original deadline. Two resets are applied, so the bench also shows that the once-per-reset marker is cleared by reset.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam logic [15:0] KEY_VALUE     = 16'h2D52;
  localparam logic [15:0] KEY_RD_LOCKED = 16'h96A5;
  localparam logic [15:0] KEY_RD_OPEN   = 16'hA596;
  localparam logic [7:0]  CODE_OFF      = 8'h00;
  localparam logic [7:0]  CODE_ANALOG   = 8'hFF;
  localparam int          REG_KEY       = 0;
  localparam int          REG_CTRL      = 1;
  localparam int          REG_MAP0      = 2;
  localparam int          CODE_W        = 8;
endpackage

// File: rtl/pinmux_keygate.sv
module pinmux_keygate
  import pinmux_pkg::*;
#(
  parameter int TIMEOUT = 32,
  parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [15:0]      key_data,
  input  logic             reconfig_en,
  output logic             unlocked,
  output logic             configured,
  output logic [CNT_W-1:0] tmo_cnt
);
  logic key_ok;
  logic may_grant;
  logic close_now;

  assign key_ok    = key_wr && (key_data == KEY_VALUE);
  assign may_grant = !(configured && !reconfig_en);
  assign close_now = (key_wr && !key_ok) || (tmo_cnt == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked   <= 1'b0;
      configured <= 1'b0;
      tmo_cnt    <= '0;
    end else if (key_ok && may_grant) begin
      unlocked <= 1'b1;
      tmo_cnt  <= '0;
    end else if (unlocked) begin
      if (close_now) begin
        unlocked <= 1'b0;
        tmo_cnt  <= '0;
        if (!reconfig_en) configured <= 1'b1;
      end else begin
        tmo_cnt <= tmo_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_SRC  = 12,
  parameter int ADDR_W   = 5,
  localparam int MAP_W   = NUM_PINS * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              unlocked,
  output logic [MAP_W-1:0]  map_flat,
  output logic              reconfig_en,
  output logic              violation
);
  logic ctrl_hit;
  logic [NUM_PINS-1:0] map_hit;

  assign ctrl_hit = wr_en && (addr == ADDR_W'(REG_CTRL));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    localparam logic [CODE_W-1:0] DEFAULT_CODE =
      (p + 1 <= NUM_SRC) ? CODE_W'(p + 1) : CODE_OFF;
    assign map_hit[p] = wr_en && (addr == ADDR_W'(REG_MAP0 + p));
    always_ff @(posedge clk) begin
      if (rst) begin
        map_flat[p*CODE_W +: CODE_W] <= DEFAULT_CODE;
      end else if (map_hit[p] && unlocked) begin
        map_flat[p*CODE_W +: CODE_W] <= wdata[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reconfig_en <= 1'b0;
      violation   <= 1'b0;
    end else if (unlocked) begin
      if (ctrl_hit) begin
        reconfig_en <= wdata[0];
        if (wdata[1]) violation <= 1'b0;
      end
    end else if (ctrl_hit || (|map_hit)) begin
      violation <= 1'b1;
    end
  end
endmodule

// File: rtl/pinmux_lane.sv
module pinmux_lane
  import pinmux_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_SRC-1:0] periph,
  output logic              pin_q,
  output logic              ana_q
);
  logic pick;
  logic is_analog;

  assign is_analog = (code == CODE_ANALOG);

  always_comb begin
    pick = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (code == CODE_W'(s + 1)) pick = periph[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      ana_q <= 1'b0;
    end else begin
      pin_q <= pick && !is_analog;
      ana_q <= is_analog;
    end
  end
endmodule

// File: rtl/pinmux_xbar.sv
module pinmux_xbar
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_SRC  = 12,
  parameter int ADDR_W   = 5,
  parameter int TIMEOUT  = 32,
  localparam int MAP_W   = NUM_PINS * CODE_W,
  localparam int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr_en,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]  periph_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_analog_dis
);
  logic             unlocked;
  logic             configured;
  logic [CNT_W-1:0] tmo_cnt;
  logic [MAP_W-1:0] map_flat;
  logic             reconfig_en;
  logic             violation;
  logic             key_wr;
  logic [15:0]      rd_next;

  assign key_wr = bus_wr_en && (bus_addr == ADDR_W'(REG_KEY));

  pinmux_keygate #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .key_wr     (key_wr),
    .key_data   (bus_wdata),
    .reconfig_en(reconfig_en),
    .unlocked   (unlocked),
    .configured (configured),
    .tmo_cnt    (tmo_cnt)
  );

  pinmux_regs #(.NUM_PINS(NUM_PINS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr_en),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .unlocked   (unlocked),
    .map_flat   (map_flat),
    .reconfig_en(reconfig_en),
    .violation  (violation)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    pinmux_lane #(.NUM_SRC(NUM_SRC)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .code  (map_flat[p*CODE_W +: CODE_W]),
      .periph(periph_in),
      .pin_q (pin_out[p]),
      .ana_q (pin_analog_dis[p])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(REG_KEY)) begin
      rd_next = unlocked ? KEY_RD_OPEN : KEY_RD_LOCKED;
    end else if (bus_addr == ADDR_W'(REG_CTRL)) begin
      rd_next = {12'd0, configured, unlocked, violation, reconfig_en};
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bus_addr == ADDR_W'(REG_MAP0 + p)) rd_next = {8'd0, map_flat[p*CODE_W +: CODE_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/pinmux_xbar_chk.sv
module pinmux_xbar_chk
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 5,
  parameter int TIMEOUT  = 32,
  parameter int MAP_W    = NUM_PINS * CODE_W,
  parameter int CNT_W    = $clog2(TIMEOUT + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr_en,
  input logic [15:0]         bus_wdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_analog_dis,
  input logic                unlocked,
  input logic                configured,
  input logic                reconfig_en,
  input logic [CNT_W-1:0]    tmo_cnt,
  input logic [MAP_W-1:0]    map_flat
);
  logic key_wr;
  assign key_wr = bus_wr_en && (bus_addr == ADDR_W'(REG_KEY));

  AST_GRANT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (key_wr && bus_wdata == KEY_VALUE && !configured) |=> unlocked); // R2

  AST_LOCKED_MAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!unlocked) |=> $stable(map_flat)); // R4

  AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (unlocked && key_wr && bus_wdata != KEY_VALUE) |=> !unlocked); // R5

  AST_WINDOW_EXPIRES: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !key_wr && tmo_cnt == CNT_W'(TIMEOUT - 1)) |=> !unlocked); // R6

  AST_CONFIGURED_STAYS_SHUT: assert property (@(posedge clk) disable iff (rst)
    (configured && !reconfig_en) |=> !unlocked); // R7

  AST_ANALOG_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((pin_out & pin_analog_dis) == '0)); // R10
endmodule

bind pinmux_xbar pinmux_xbar_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_wr_en     (bus_wr_en),
  .bus_wdata     (bus_wdata),
  .pin_out       (pin_out),
  .pin_analog_dis(pin_analog_dis),
  .unlocked      (unlocked),
  .configured    (configured),
  .reconfig_en   (reconfig_en),
  .tmo_cnt       (tmo_cnt),
  .map_flat      (map_flat)
);

// File: tb/pinmux_xbar_tb.sv
module pinmux_xbar_tb;
  localparam int NUM_PINS = 8;
  localparam int NUM_SRC  = 12;
  localparam int ADDR_W   = 5;
  localparam int TIMEOUT  = 32;
  localparam logic [NUM_SRC-1:0] PERIPH = 12'hA5C;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [ADDR_W-1:0]   bus_addr = '0;
  logic                bus_wr_en = 1'b0;
  logic [15:0]         bus_wdata = '0;
  logic [15:0]         bus_rdata;
  logic [NUM_SRC-1:0]  periph_in = PERIPH;
  logic [NUM_PINS-1:0] pin_out;
  logic [NUM_PINS-1:0] pin_analog_dis;

  always #5 clk = ~clk;

  pinmux_xbar #(.NUM_PINS(NUM_PINS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .periph_in(periph_in), .pin_out(pin_out), .pin_analog_dis(pin_analog_dis)
  );

  typedef struct {
    int          kind;
    int          idx;
    logic [15:0] exp;
    string       tag;
    int          due;
  } item_t;

  item_t q[$];
  int cycle = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cycle) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {15'd0, pin_out[it.idx]};
        default: act = {15'd0, pin_analog_dis[it.idx]};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.tag, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input int idx, input logic [15:0] exp, input string tag, input int lat);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag; it.due = cycle + lat;
    q.push_back(it);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = ADDR_W'(a);
    push(0, 0, exp, tag, 1);
  endtask

  task automatic chk_pin(input int p, input logic exp, input string tag);
    @(posedge clk); #1;
    push(1, p, {15'd0, exp}, tag, 0);
  endtask

  task automatic chk_ana(input int p, input logic exp, input string tag);
    @(posedge clk); #1;
    push(2, p, {15'd0, exp}, tag, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1'b1;
    idle(3); #1; rst = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    rd(0, 16'h96A5, "R1 key reads locked");
    rd(2 + 3, 16'd4, "R1 identity selector pin3");
    rd(1, 16'h0000, "R1 control clear");
    chk_pin(2, PERIPH[2], "R1 pin2 follows source2");
    chk_pin(6, PERIPH[6], "R1 pin6 follows source6");
    // R4: locked write ignored and flagged
    wr(2, 16'd5);
    chk_pin(0, PERIPH[0], "R4 pin0 unchanged while locked");
    rd(2, 16'd1, "R4 selector0 unchanged");
    rd(1, 16'h0002, "R4 violation flag set");
    // R5: wrong key while locked has no effect
    wr(0, 16'h1234);
    rd(0, 16'h96A5, "R5 wrong key while locked");
    // R2: correct key opens
    wr(0, 16'h2D52);
    rd(0, 16'hA596, "R2 key reads open");
    // R11: control write sets reconfig and clears violation
    wr(1, 16'h0003);
    rd(1, 16'h0005, "R11 reconfig set, violation cleared");
    wr(0, 16'h2D52);
    // R3 / R9 / R10
    wr(2 + 0, 16'd10);
    chk_pin(0, PERIPH[9], "R3 pin0 follows source9");
    wr(2 + 1, 16'd0);
    chk_pin(1, 1'b0, "R9 code0 low");
    wr(2 + 2, 16'd200);
    chk_pin(2, 1'b0, "R9 out of range code low");
    wr(2 + 3, 16'h00FF);
    chk_pin(3, 1'b0, "R10 analog pin low");
    chk_ana(3, 1'b1, "R10 analog disable set");
    chk_ana(2, 1'b0, "R10 non-analog pin clear");
    wr(2 + 4, 16'd12);
    chk_pin(4, PERIPH[11], "R3 pin4 follows source11");
    // R5: wrong key while open closes
    wr(0, 16'h0000);
    rd(0, 16'h96A5, "R5 wrong key closes window");
    wr(2 + 0, 16'd3);
    rd(2, 16'd10, "R5 selector0 kept after close");
    // R8: reopen with reconfig enabled
    wr(0, 16'h2D52);
    rd(0, 16'hA596, "R8 reopen allowed");
    // R6: window expires
    idle(40);
    rd(0, 16'h96A5, "R6 window expired");
    rd(1, 16'h0003, "R6 locked, reconfig kept, violation kept");
    // R12: refresh restarts the counter
    wr(0, 16'h2D52);
    idle(20);
    wr(0, 16'h2D52);
    idle(20);
    wr(2 + 5, 16'd7);
    chk_pin(5, PERIPH[6], "R12 write accepted after refresh");
    // R7: once-per-reset policy
    wr(1, 16'h0002);
    wr(0, 16'hBEEF);
    rd(1, 16'h0008, "R7 configured marker set");
    wr(0, 16'h2D52);
    rd(0, 16'h96A5, "R7 key refused once configured");
    wr(2 + 5, 16'd0);
    chk_pin(5, PERIPH[6], "R7 mapping frozen");
    // R1 / R7: reset clears the marker
    do_reset();
    rd(2, 16'd1, "R1 selector0 back to identity");
    rd(1, 16'h0000, "R7 marker cleared by reset");
    wr(0, 16'h2D52);
    rd(0, 16'hA596, "R7 key accepted after reset");
    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule